// File: doc/BRIEF.md
# Second-Stage Guest-to-Host Address Walker

This block turns a guest-physical address, which the guest has already produced with its own page tables, into a host-physical address. It walks a second-stage table tree of up to four levels held in host memory. Each level is one 64-bit entry fetched over a simple request/response memory port. The last-level entry grants read, write and execute rights separately, and the block checks the requested access against them.

Only one translation is in flight at a time. A walk ends in one of two ways. It can end with a one-cycle done pulse carrying the host-physical address. It can also end with a one-cycle violation pulse carrying a record for the hypervisor exit path: the guest-physical address, the access type, the level where the walk stopped, and whether the walk stopped because the mapping was absent or because the right was missing. The hypervisor can then install a mapping and issue the same request again.

Top module: `s2_xlate`

## Requirements
- R1: While reset is held, and right after it is released, `req_ready_o` is 1 and `done_o`, `viol_o` and `mem_req_o` are 0.
- R2: A walk starts at `root_base_i`. At each level L (0 = top) it reads one 8-byte entry at address table_base + index×8. The index is the 9-bit field of the guest address at bits [20+9×(3−L) : 12+9×(3−L)], so level 0 uses [47:39] and level 3 uses [20:12]. The next table base is entry bits [51:12] followed by 12 zero bits.
- R3: On success, `done_o` pulses for exactly one cycle. `hpa_o` = {leaf entry bits [51:12], guest address bits [11:0]}.
- R4: An entry is present only if at least one of its bits [2:0] is set. A non-present entry at level L ends the walk with a violation: cause 0 (not present), level L. No further table reads are made. A walk that stops at level L makes exactly L+1 reads.
- R5: The leaf (level 3) right is taken from bit 0 for access code 0 (read), bit 1 for code 1 (write) and bit 2 for code 2 (execute). If the needed bit is clear, the walk ends with a violation: cause 1 (permission), level 3, after 4 reads.
- R6: `viol_o` pulses for exactly one cycle. During that pulse, `viol_gpa_o` and `viol_acc_o` equal the request's address and access code. `done_o` and `viol_o` are never high together.
- R7: `req_ready_o` drops the cycle after a request is accepted and stays low until the result pulse. A `req_valid_i` presented while `req_ready_o` is low is ignored and does not change the result of the walk in flight.
- R8: After a violation, once the hypervisor has installed the missing entries, the same request translates successfully.
- R9: `mem_req_o` is a one-cycle pulse per entry read. No new read is issued until the previous read's response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_base_i | input | 52 | Host-physical base of the top-level table, 4 KiB aligned |
| req_valid_i | input | 1 | Translation request strobe |
| req_gpa_i | input | 48 | Guest-physical address to translate |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_ready_o | output | 1 | Walker is idle and will accept a request |
| mem_req_o | output | 1 | Table entry read strobe |
| mem_addr_o | output | 52 | Host-physical address of the entry being read |
| mem_rsp_valid_i | input | 1 | Entry read data is valid |
| mem_rsp_data_i | input | 64 | 64-bit table entry |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| hpa_o | output | 52 | Translated host-physical address |
| viol_o | output | 1 | One-cycle pulse: exit to hypervisor |
| viol_gpa_o | output | 48 | Faulting guest-physical address |
| viol_acc_o | output | 2 | Faulting access type |
| viol_level_o | output | 2 | Level where the walk stopped |
| viol_cause_o | output | 1 | 0 not present, 1 permission denied |

## Verification
A wrong level counter or a wrong index selection shows up at the ports on the very first read of a walk. The entry address on `mem_addr_o` is off, and the number of read strobes before the result pulse is wrong. A stale table base only appears as a wrong host address, or as a spurious not-present exit, at the end of a full four-read walk. A permission decode that picks the wrong bit is exposed by translating the same leaf with all three access types. A busy flag that clears early lets an ignored request replace the captured address, which shows as a mismatched result address within one walk.

// File: rtl/s2_xlate_pkg.sv
package s2_xlate_pkg;
  localparam int ENTRY_W = 64;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic {
    CAUSE_NP   = 1'b0,
    CAUSE_PERM = 1'b1
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/s2_idx_sel.sv
module s2_idx_sel #(
  parameter int GPA_W  = 48,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PAGE_W = 12,
  parameter int LVL_W  = 2
) (
  input  logic [GPA_W-1:0] gpa_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] fld [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = gpa_i[PAGE_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign idx_o = fld[lvl_i];

  logic unused_pg;
  assign unused_pg = ^gpa_i[PAGE_W-1:0];
endmodule

// File: rtl/s2_entry_chk.sv
module s2_entry_chk
  import s2_xlate_pkg::*;
#(
  parameter int HPA_W  = 52,
  parameter int PAGE_W = 12
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  acc_e               acc_i,
  output logic               present_o,
  output logic               allowed_o,
  output logic [HPA_W-1:0]   next_base_o
);
  logic [2:0] perm;
  assign perm        = entry_i[2:0];
  assign present_o   = |perm;
  assign next_base_o = {entry_i[HPA_W-1:PAGE_W], {PAGE_W{1'b0}}};

  always_comb begin
    unique case (acc_i)
      ACC_RD:  allowed_o = perm[0];
      ACC_WR:  allowed_o = perm[1];
      ACC_EX:  allowed_o = perm[2];
      default: allowed_o = 1'b0;
    endcase
  end

  logic unused_ent;
  assign unused_ent = ^{entry_i[ENTRY_W-1:HPA_W], entry_i[PAGE_W-1:3]};
endmodule

// File: rtl/s2_xlate.sv
module s2_xlate
  import s2_xlate_pkg::*;
#(
  parameter int GPA_W  = 48,
  parameter int HPA_W  = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PAGE_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HPA_W-1:0]     root_base_i,
  input  logic                 req_valid_i,
  input  logic [GPA_W-1:0]     req_gpa_i,
  input  logic [1:0]           req_acc_i,
  output logic                 req_ready_o,
  output logic                 mem_req_o,
  output logic [HPA_W-1:0]     mem_addr_o,
  input  logic                 mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0]   mem_rsp_data_i,
  output logic                 done_o,
  output logic [HPA_W-1:0]     hpa_o,
  output logic                 viol_o,
  output logic [GPA_W-1:0]     viol_gpa_o,
  output logic [1:0]           viol_acc_o,
  output logic [1:0]           viol_level_o,
  output logic                 viol_cause_o
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);
  localparam int PAD_W = HPA_W - IDX_W - 3;

  st_e               state_q;
  logic [GPA_W-1:0]  gpa_q;
  acc_e              acc_q;
  logic [HPA_W-1:0]  base_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              done_q, viol_q;
  cause_e            cause_q;
  logic [HPA_W-1:0]  hpa_q;

  logic [IDX_W-1:0]  idx;
  logic              present, allowed;
  logic [HPA_W-1:0]  next_base;
  logic              accept;

  s2_idx_sel #(
    .GPA_W(GPA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_W(PAGE_W), .LVL_W(LVL_W)
  ) u_idx (
    .gpa_i (gpa_q),
    .lvl_i (lvl_q),
    .idx_o (idx)
  );

  s2_entry_chk #(.HPA_W(HPA_W), .PAGE_W(PAGE_W)) u_chk (
    .entry_i     (mem_rsp_data_i),
    .acc_i       (acc_q),
    .present_o   (present),
    .allowed_o   (allowed),
    .next_base_o (next_base)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mem_req_o   = (state_q == ST_ISSUE);
  assign mem_addr_o  = base_q | {{PAD_W{1'b0}}, idx, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gpa_q   <= '0;
      acc_q   <= ACC_RD;
      base_q  <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      viol_q  <= 1'b0;
      cause_q <= CAUSE_NP;
      hpa_q   <= '0;
    end else begin
      done_q <= 1'b0;
      viol_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          gpa_q   <= req_gpa_i;
          acc_q   <= acc_e'(req_acc_i);
          base_q  <= root_base_i;
          lvl_q   <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!present) begin
            viol_q  <= 1'b1;
            cause_q <= CAUSE_NP;
            state_q <= ST_IDLE;
          end else if (lvl_q != LAST_LVL) begin
            base_q  <= next_base;
            lvl_q   <= lvl_q + LVL_W'(1);
            state_q <= ST_ISSUE;
          end else if (allowed) begin
            done_q  <= 1'b1;
            hpa_q   <= {next_base[HPA_W-1:PAGE_W], gpa_q[PAGE_W-1:0]};
            state_q <= ST_IDLE;
          end else begin
            viol_q  <= 1'b1;
            cause_q <= CAUSE_PERM;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o       = done_q;
  assign hpa_o        = hpa_q;
  assign viol_o       = viol_q;
  assign viol_gpa_o   = gpa_q;
  assign viol_acc_o   = acc_q;
  assign viol_level_o = 2'(lvl_q);
  assign viol_cause_o = cause_q;

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && viol_o));

  p_viol_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> !viol_o);

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  p_rd_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_rd_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  p_perm_leaf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && viol_cause_o) |-> (viol_level_o == 2'(LAST_LVL)));
endmodule

// File: tb/sim_s2_xlate.sv
module sim_s2_xlate;
  localparam logic [51:0] ROOT = 52'h1000;
  localparam int NV = 10;

  localparam logic [47:0] GA = 48'h0000_1234_5ABC;
  localparam logic [47:0] GB = 48'h7F80_0020_3123;
  localparam logic [47:0] GC = 48'h0000_1234_6010;
  localparam logic [47:0] GD = 48'hFFFF_FFFF_F000;
  localparam logic [47:0] GE = 48'h0000_1260_0000;
  localparam logic [47:0] GF = 48'h0000_1280_0000;

  localparam logic [47:0] V_GPA [NV] = '{GA, GA, GA, GB, GB, GC, GC, GD, GE, GF};
  localparam logic [1:0]  V_ACC [NV] = '{0, 1, 2, 1, 2, 2, 0, 0, 1, 0};
  localparam bit          V_VIO [NV] = '{0, 1, 1, 0, 1, 0, 1, 1, 1, 1};
  localparam logic [51:0] V_HPA [NV] = '{52'h0000ABCDEFABC, 0, 0, 52'h1234567890123, 0,
                                         52'h0000055555010, 0, 0, 0, 0};
  localparam logic [1:0]  V_LVL [NV] = '{3, 3, 3, 3, 3, 3, 3, 0, 2, 2};
  localparam bit          V_CAU [NV] = '{0, 1, 1, 0, 1, 0, 1, 0, 0, 0};
  localparam int          V_RDS [NV] = '{4, 4, 4, 4, 4, 4, 4, 1, 3, 3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_gpa = '0;
  logic [1:0]  req_acc = '0;
  logic        req_ready, mem_req, rsp_v, done, viol, viol_cause;
  logic [51:0] mem_addr, hpa;
  logic [63:0] rsp_d;
  logic [47:0] viol_gpa;
  logic [1:0]  viol_acc, viol_level;

  always #5 clk = ~clk;

  s2_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .root_base_i(ROOT),
    .req_valid_i(req_valid), .req_gpa_i(req_gpa), .req_acc_i(req_acc),
    .req_ready_o(req_ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_data_i(rsp_d),
    .done_o(done), .hpa_o(hpa), .viol_o(viol), .viol_gpa_o(viol_gpa),
    .viol_acc_o(viol_acc), .viol_level_o(viol_level), .viol_cause_o(viol_cause)
  );

  logic [63:0] mem [logic [51:0]];
  logic [51:0] next_tbl = 52'h2000;
  int          total_rd = 0;
  logic [51:0] rd_log [16];
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) begin
    rsp_v <= mem_req;
    rsp_d <= (mem_req && mem.exists(mem_addr)) ? mem[mem_addr] : 64'h0;
    if (mem_req) begin
      rd_log[total_rd % 16] <= mem_addr;
      total_rd <= total_rd + 1;
    end
  end

  initial begin
    rsp_v = 1'b0;
    rsp_d = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act %0d cycles exp < 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act %h exp %h", req, what, act, expv);
    end
  endtask

  function automatic logic [8:0] idxf(input logic [47:0] g, input int l);
    return g[12 + 9*(3-l) +: 9];
  endfunction

  task automatic put(input logic [47:0] g, input int stop, input logic [63:0] ent);
    logic [51:0] t = ROOT;
    logic [51:0] ea;
    for (int l = 0; l < stop; l++) begin
      ea = t | (52'(idxf(g, l)) << 3);
      if (!mem.exists(ea) || mem[ea][2:0] == 3'b000) begin
        mem[ea] = {12'h0, next_tbl[51:12], 9'h0, 3'b111};
        next_tbl += 52'h1000;
      end
      t = {mem[ea][51:12], 12'h0};
    end
    ea = t | (52'(idxf(g, stop)) << 3);
    mem[ea] = ent;
  endtask

  function automatic logic [63:0] leaf(input logic [39:0] b, input logic [2:0] p);
    return {12'h0, b, 9'h0, p};
  endfunction

  bit          got_done, got_viol;
  logic [51:0] c_hpa, first_addr;
  logic [47:0] c_gpa;
  logic [1:0]  c_acc, c_lvl;
  logic        c_cause;
  int          n_rd;

  task automatic walk(input logic [47:0] g, input logic [1:0] a, input bit poke);
    int start;
    bit fin = 0;
    got_done = 0; got_viol = 0;
    @(negedge clk);
    start = total_rd;
    req_valid = 1'b1; req_gpa = g; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
      req_valid = 1'b1; req_gpa = GD; req_acc = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i < 60 && !fin; i++) begin
      if (done || viol) begin
        fin = 1;
        got_done = done; got_viol = viol;
        c_hpa = hpa; c_gpa = viol_gpa; c_acc = viol_acc;
        c_lvl = viol_level; c_cause = viol_cause;
      end else @(negedge clk);
    end
    n_rd = total_rd - start;
    first_addr = rd_log[start % 16];
    if (!fin) chk(0, "R3", "walk timeout", 0, 1);
    @(negedge clk);
    chk(!done && !viol, "R6", "result pulse width", {done, viol}, 0);
    chk(req_ready, "R7", "ready after result", req_ready, 1);
  endtask

  initial begin
    put(GA, 3, leaf(40'h00000ABCDEF, 3'b001));
    put(GB, 3, leaf(40'h1234567890, 3'b011));
    put(GC, 3, leaf(40'h0000055555, 3'b100));
    put(GF, 2, {12'h0, 40'h0000000009, 9'h0, 3'b000});

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !viol && !mem_req, "R1", "outputs in reset",
        {req_ready, done, viol, mem_req}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !viol && !mem_req, "R1", "outputs after reset",
        {req_ready, done, viol, mem_req}, 4'b1000);

    for (int v = 0; v < NV; v++) begin
      walk(V_GPA[v], V_ACC[v], 0);
      chk(first_addr == (ROOT | (52'(idxf(V_GPA[v], 0)) << 3)), "R2", "first entry addr",
          first_addr, ROOT | (52'(idxf(V_GPA[v], 0)) << 3));
      chk(n_rd == V_RDS[v], V_VIO[v] ? "R4" : "R2", "read count", n_rd, V_RDS[v]);
      if (!V_VIO[v]) begin
        chk(got_done && !got_viol, "R3", "done expected", {got_done, got_viol}, 2'b10);
        chk(c_hpa == V_HPA[v], "R3", "hpa", c_hpa, V_HPA[v]);
      end else begin
        chk(got_viol && !got_done, "R6", "violation expected", {got_done, got_viol}, 2'b01);
        chk(c_gpa == V_GPA[v] && c_acc == V_ACC[v], "R6", "record gpa/acc",
            {c_gpa, c_acc}, {V_GPA[v], V_ACC[v]});
        chk(c_lvl == V_LVL[v], V_CAU[v] ? "R5" : "R4", "stop level", c_lvl, V_LVL[v]);
        chk(c_cause == V_CAU[v], V_CAU[v] ? "R5" : "R4", "cause", c_cause, V_CAU[v]);
      end
    end

    // R7: request while busy is ignored
    walk(GB, 2'd1, 1);
    chk(got_done && c_hpa == 52'h1234567890123, "R7", "busy request ignored",
        c_hpa, 52'h1234567890123);
    chk(n_rd == 4, "R7", "reads with ignored request", n_rd, 4);

    // R8: hypervisor installs mapping, retry succeeds
    walk(GD, 2'd0, 0);
    chk(got_viol && c_lvl == 0, "R8", "fault before install", c_lvl, 0);
    put(GD, 3, leaf(40'h00000C0FFE, 3'b001));
    walk(GD, 2'd0, 0);
    chk(got_done && c_hpa == 52'h00000C0FFE000, "R8", "retry hpa", c_hpa, 52'h00000C0FFE000);
    chk(n_rd == 4, "R9", "one read per level", n_rd, 4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule